// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Locked-Entry Protection

This block is a fully associative translation buffer of 64 entries. Each entry is a tag paired with a 64-bit data word. The block never fills itself. Software loads it with register-style writes. First it writes the virtual tag into a staging register. It then writes a data word in one of two ways. An automatic-placement write lets the block choose the victim. An indexed write names the entry directly by address bits.

Two bits of the data word have fixed meaning. Bit 63 marks the entry valid and bit 6 marks it locked. Automatic placement takes the lowest-numbered invalid entry. If every entry is valid, it takes the lowest-numbered unlocked entry. A locked entry is therefore never displaced automatically. If the buffer is full of locked entries, the write is dropped and a status flag reports the refusal.

A combinational lookup port compares a presented tag against every valid entry. It returns hit, the index of the winning entry and that entry's data. A single-cycle global invalidate clears the valid bit of every entry.

Top module: `xtlb_top`

## Requirements
- R1: After reset every entry is invalid, `lk_hit` is 0, `fill_fail` is 0 and the staging tag register holds 0.
- R2: `tag_we` loads `tag_wdata` into the staging tag register at the clock edge. A write to any entry in that same cycle stores the register's previous value as the tag.
- R3: An automatic-placement write (`fill_we`) goes to the lowest-indexed entry whose data bit 63 is 0.
- R4: When every entry has bit 63 set, the automatic-placement write goes to the lowest-indexed entry whose data bit 6 is 0.
- R5: When every entry has both bit 63 and bit 6 set, the automatic-placement write changes no entry and `fill_fail` reads 1 from the next cycle on. Any automatic-placement write that is carried out sets `fill_fail` back to 0. In cycles without such a write, `fill_fail` holds its value.
- R6: The chosen entry receives the staging tag register as its tag and `wdata` as its data word.
- R7: An indexed write (`idx_we`) stores the staging tag and `wdata` into the entry numbered by `idx_addr[8:3]`, whatever that entry's valid and lock bits are.
- R8: The lookup port hits only on an entry with bit 63 set whose tag equals `lk_tag`. Among several such entries the lowest index wins. `lk_index` and `lk_data` describe the winner in the same cycle, with no clock delay.
- R9: `inval_all` clears bit 63 of every entry at one clock edge. Any indexed or automatic-placement write in that cycle is discarded, and `fill_fail` keeps its value.
- R10: When `idx_we` and `fill_we` are both high, only the indexed write takes effect, and `fill_fail` keeps its value.
- R11: An entry written with bit 63 clear is stored but never hits, and it stays a candidate for automatic placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_we | input | 1 | Load the staging tag register |
| tag_wdata | input | TAG_W | Value for the staging tag register |
| fill_we | input | 1 | Automatic-placement write |
| idx_we | input | 1 | Indexed write |
| idx_addr | input | ADDR_W | Address of the indexed write; bits [8:3] select the entry |
| wdata | input | 64 | Data word for either write |
| inval_all | input | 1 | Clear the valid bit of every entry |
| lk_tag | input | TAG_W | Tag to look up |
| lk_hit | output | 1 | A valid entry matches `lk_tag` |
| lk_index | output | 6 | Index of the matching entry |
| lk_data | output | 64 | Data word of the matching entry |
| fill_fail | output | 1 | The last automatic-placement write carried out or refused was refused |

## Verification
Several properties are checked on every cycle. A refused placement raises the status flag, and the flag rises only after a placement request. Both kinds of write land the supplied word in the entry they target. The chosen victim is never both valid and locked. A hit always carries a valid word, and the lookup is empty right after a global invalidate.

Other behaviours can be shown only by the bench's scenarios, compared against a behavioural model on every clock. These are the preference for the lowest invalid entry over the lowest unlocked one, and the tie-break among duplicate tags. They also cover the use of the old staging tag when it is rewritten in the same cycle, and the discarding of writes under invalidate or alongside an indexed write.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned VALID_POS = 63;
  localparam int unsigned LOCK_POS  = 6;
  localparam int unsigned SLOT_LSB  = 3;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/xtlb_first_set.sv
module xtlb_first_set #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the lowest assignment is last
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  valid_vec,
  input  logic [N-1:0]  lock_vec,
  output logic          ok,
  output logic [IW-1:0] idx
);
  logic          free_found, unl_found;
  logic [IW-1:0] free_idx, unl_idx;

  xtlb_first_set #(.N(N), .IW(IW)) u_free (
    .vec(~valid_vec), .found(free_found), .idx(free_idx)
  );
  xtlb_first_set #(.N(N), .IW(IW)) u_unlocked (
    .vec(~lock_vec), .found(unl_found), .idx(unl_idx)
  );

  // an invalid slot is preferred; otherwise any slot not pinned by its lock bit
  always_comb begin
    ok  = free_found | unl_found;
    idx = free_found ? free_idx : unl_idx;
  end
endmodule

// File: rtl/xtlb_top.sv
module xtlb_top #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 32,
  parameter int unsigned ADDR_W  = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned DW     = xtlb_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_we,
  input  logic [TAG_W-1:0]  tag_wdata,
  input  logic              fill_we,
  input  logic              idx_we,
  input  logic [ADDR_W-1:0] idx_addr,
  input  logic [DW-1:0]     wdata,
  input  logic              inval_all,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_index,
  output logic [DW-1:0]     lk_data,
  output logic              fill_fail
);
  import xtlb_pkg::*;

  localparam int unsigned VP = VALID_POS;
  localparam int unsigned LP = LOCK_POS;

  logic [TAG_W-1:0] stage_q, stage_d;
  logic             stage_en;
  logic             fail_q, fail_d, fail_en;

  logic [TAG_W-1:0] ent_tag_q  [ENTRIES];
  word_t            ent_data_q [ENTRIES];

  logic [ENTRIES-1:0] valid_vec, lock_vec, hit_vec;
  logic               vic_ok;
  logic [IDX_W-1:0]   vic_idx;
  logic [IDX_W-1:0]   slot_sel;
  logic               idx_go, fill_go, fill_ok;

  assign slot_sel = idx_addr[SLOT_LSB +: IDX_W];

  // write arbitration: invalidate beats both writes, indexed beats placement
  always_comb begin
    idx_go  = idx_we & ~inval_all;
    fill_go = fill_we & ~idx_we & ~inval_all;
    fill_ok = fill_go & vic_ok;
  end

  // staging tag and status flag next state
  always_comb begin
    stage_en = tag_we;
    stage_d  = tag_wdata;
    fail_en  = fill_go;
    fail_d   = ~vic_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (fail_en)  fail_q  <= fail_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [TAG_W-1:0] tag_d;
    word_t            data_d;
    logic             en;

    always_comb begin
      tag_d  = ent_tag_q[g];
      data_d = ent_data_q[g];
      en     = 1'b0;
      if (inval_all) begin
        data_d[VP] = 1'b0;
        en         = 1'b1;
      end else if ((idx_go && slot_sel == IDX_W'(g)) ||
                   (fill_ok && vic_idx == IDX_W'(g))) begin
        tag_d  = stage_q;
        data_d = wdata;
        en     = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_tag_q[g]  <= '0;
        ent_data_q[g] <= '0;
      end else if (en) begin
        ent_tag_q[g]  <= tag_d;
        ent_data_q[g] <= data_d;
      end
    end

    always_comb begin
      valid_vec[g] = ent_data_q[g][VP];
      lock_vec[g]  = ent_data_q[g][LP];
      hit_vec[g]   = ent_data_q[g][VP] && (ent_tag_q[g] == lk_tag);
    end
  end

  xtlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
    .valid_vec(valid_vec), .lock_vec(lock_vec), .ok(vic_ok), .idx(vic_idx)
  );

  xtlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_match (
    .vec(hit_vec), .found(lk_hit), .idx(lk_index)
  );

  assign lk_data   = lk_hit ? ent_data_q[lk_index] : '0;
  assign fill_fail = fail_q;
endmodule

// File: rtl/xtlb_chk.sv
module xtlb_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IDX_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fill_we,
  input logic                idx_we,
  input logic [ADDR_W-1:0]   idx_addr,
  input logic                inval_all,
  input logic [63:0]         wdata,
  input logic                lk_hit,
  input logic [63:0]         lk_data,
  input logic                fill_fail,
  input logic                vic_ok,
  input logic [IDX_W-1:0]    vic_idx,
  input logic [63:0]         ent_data [ENTRIES]
);
  localparam int unsigned VP = xtlb_pkg::VALID_POS;
  localparam int unsigned LP = xtlb_pkg::LOCK_POS;
  localparam int unsigned SL = xtlb_pkg::SLOT_LSB;

  // R5
  fill_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !idx_we && !inval_all && !vic_ok) |=> fill_fail);

  // R5
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_fail) |-> $past(fill_we));

  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !idx_we && !inval_all && vic_ok) |=>
      ent_data[$past(vic_idx)] == $past(wdata));

  // R7
  idx_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && !inval_all) |=>
      ent_data[$past(idx_addr[SL +: IDX_W])] == $past(wdata));

  // R4
  victim_not_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_ok |-> !(ent_data[vic_idx][VP] && ent_data[vic_idx][LP]));

  // R8
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_data[VP]);

  // R9
  inval_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !lk_hit);
endmodule

bind xtlb_top xtlb_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .idx_we(idx_we),
  .idx_addr(idx_addr), .inval_all(inval_all), .wdata(wdata),
  .lk_hit(lk_hit), .lk_data(lk_data), .fill_fail(fill_fail),
  .vic_ok(vic_ok), .vic_idx(vic_idx), .ent_data(ent_data_q)
);

// File: tb/test_xtlb_top.sv
`timescale 1ns/1ps
module test_xtlb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tag_we, fill_we, idx_we, inval_all;
  logic [31:0] tag_wdata, lk_tag;
  logic [15:0] idx_addr;
  logic [63:0] wdata, lk_data;
  logic        lk_hit, fill_fail;
  logic [5:0]  lk_index;

  int n_cmp  = 0;
  int n_fail = 0;

  // behavioural reference state
  logic [63:0] m_data [N];
  logic [31:0] m_tag  [N];
  logic [31:0] m_stage;
  logic        m_fail;

  always #2.5 clk = ~clk;

  xtlb_top i_xtlb_top (
    .clk(clk), .rst_n(rst_n), .tag_we(tag_we), .tag_wdata(tag_wdata),
    .fill_we(fill_we), .idx_we(idx_we), .idx_addr(idx_addr), .wdata(wdata),
    .inval_all(inval_all), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .lk_index(lk_index), .lk_data(lk_data), .fill_fail(fill_fail)
  );

  function automatic logic [63:0] mk(bit v, bit l, int pay);
    logic [63:0] d;
    d     = 64'(pay) << 8;
    d[63] = v;
    d[6]  = l;
    return d;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_data[i] = '0;
      m_tag[i]  = '0;
    end
    m_stage = '0;
    m_fail  = 1'b0;
  endtask

  // one clock edge of the reference model, using the inputs held at that edge
  task automatic model_step();
    logic [31:0] old_stage;
    int v;
    old_stage = m_stage;
    if (inval_all) begin
      for (int i = 0; i < N; i++) m_data[i][63] = 1'b0;
    end else if (idx_we) begin
      m_data[idx_addr[8:3]] = wdata;
      m_tag[idx_addr[8:3]]  = old_stage;
    end else if (fill_we) begin
      v = -1;
      for (int i = 0; i < N; i++) if (v < 0 && !m_data[i][63]) v = i;
      for (int i = 0; i < N; i++) if (v < 0 && !m_data[i][6])  v = i;
      if (v >= 0) begin
        m_data[v] = wdata;
        m_tag[v]  = old_stage;
        m_fail    = 1'b0;
      end else begin
        m_fail = 1'b1;
      end
    end
    if (tag_we) m_stage = tag_wdata;
  endtask

  task automatic compare_all();
    int w;
    w = -1;
    for (int i = 0; i < N; i++) if (w < 0 && m_data[i][63] && m_tag[i] == lk_tag) w = i;
    check("R8 hit", 64'(lk_hit), 64'(w >= 0));
    if (w >= 0) begin
      check("R8 index", 64'(lk_index), 64'(w));
      check("R8 data", lk_data, m_data[w]);
    end
    check("R5 fill_fail", 64'(fill_fail), 64'(m_fail));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    tag_we = 0; fill_we = 0; idx_we = 0; inval_all = 0;
  endtask

  task automatic set_tag(logic [31:0] t);
    tag_we = 1; tag_wdata = t; cyc();
  endtask

  task automatic fill(logic [63:0] d);
    fill_we = 1; wdata = d; cyc();
  endtask

  task automatic idxw(int i, logic [63:0] d);
    idx_we = 1; idx_addr = 16'(i) << 3; wdata = d; cyc();
  endtask

  task automatic look(logic [31:0] t);
    lk_tag = t; #0.1; compare_all();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    tag_we = 0; fill_we = 0; idx_we = 0; inval_all = 0;
    tag_wdata = 0; idx_addr = 0; wdata = 0; lk_tag = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 hit", 64'(lk_hit), 64'd0);
    check("R1 fill_fail", 64'(fill_fail), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R2: placement in the same cycle as a tag load stores the old tag (0)
    tag_we = 1; tag_wdata = 32'd77; fill_we = 1; wdata = mk(1, 0, 1); cyc();
    look(32'd0);
    check("R2 old tag used", 64'(lk_hit), 64'd1);
    look(32'd77);
    check("R2 new tag not stored", 64'(lk_hit), 64'd0);

    // R9: invalidate drops a concurrent placement
    inval_all = 1; fill_we = 1; wdata = mk(1, 0, 2); cyc();
    look(32'd0);
    check("R9 cleared", 64'(lk_hit), 64'd0);
    look(32'd77);
    check("R9 write dropped", 64'(lk_hit), 64'd0);

    // R3/R6: fill the whole buffer, entries 5 and 9 unlocked
    for (int i = 0; i < N; i++) begin
      set_tag(32'(1000 + i));
      fill(mk(1, (i != 5 && i != 9), i));
    end
    look(32'd1000 + 32'd37);
    check("R3 lowest invalid order", 64'(lk_index), 64'd37);
    check("R6 data", lk_data, mk(1, 1, 37));

    // R4: full buffer, lowest unlocked entry is replaced
    set_tag(32'd2000);
    fill(mk(1, 1, 500));
    look(32'd2000);
    check("R4 victim", 64'(lk_index), 64'd5);
    look(32'd1005);
    check("R4 old gone", 64'(lk_hit), 64'd0);
    set_tag(32'd2001);
    fill(mk(1, 1, 501));
    look(32'd2001);
    check("R4 next victim", 64'(lk_index), 64'd9);

    // R5: everything valid and locked, placement refused
    set_tag(32'd2002);
    fill(mk(1, 0, 502));
    check("R5 flag", 64'(fill_fail), 64'd1);
    look(32'd2002);
    check("R5 nothing stored", 64'(lk_hit), 64'd0);
    cyc();
    check("R5 flag holds", 64'(fill_fail), 64'd1);

    // R7/R11: indexed write of an invalid word into a locked slot
    set_tag(32'd3000);
    idxw(20, mk(0, 1, 600));
    look(32'd3000);
    check("R11 invalid no hit", 64'(lk_hit), 64'd0);
    set_tag(32'd3001);
    fill(mk(1, 1, 601));
    look(32'd3001);
    check("R11 slot reusable", 64'(lk_index), 64'd20);
    check("R5 flag cleared", 64'(fill_fail), 64'd0);

    // R8: duplicate tag, lowest index wins
    set_tag(32'd1003);
    idxw(30, mk(1, 1, 700));
    look(32'd1003);
    check("R8 lowest wins", 64'(lk_index), 64'd3);

    // R10: indexed and placement together, only indexed acts
    set_tag(32'd4000);
    idxw(7, mk(1, 1, 800));
    inval_all = 1; cyc();
    set_tag(32'd4001);
    idx_we = 1; idx_addr = 16'd40 << 3; wdata = mk(1, 0, 900); fill_we = 1; cyc();
    look(32'd4001);
    check("R10 indexed applied", 64'(lk_index), 64'd40);
    check("R10 data", lk_data, mk(1, 0, 900));
    set_tag(32'd4002);
    fill(mk(1, 0, 901));
    look(32'd4002);
    check("R10 placement was dropped", 64'(lk_index), 64'd0);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      tag_we    = ($urandom_range(0, 9) < 3);
      tag_wdata = 32'($urandom_range(0, 15));
      fill_we   = ($urandom_range(0, 3) == 0);
      idx_we    = ($urandom_range(0, 6) == 0);
      idx_addr  = 16'($urandom);
      wdata     = mk($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 7, int'($urandom_range(0, 9999)));
      inval_all = ($urandom_range(0, 49) == 0);
      lk_tag    = 32'($urandom_range(0, 15));
      cyc();
    end

    summary();
    $finish;
  end
endmodule